// File: doc/BRIEF.md
# Cascadable Dual Pacer Generator

This block turns a fixed-rate base clock enable into two independent streams of one-cycle pacer ticks. One stream paces input sampling and the other paces output release. Each stream comes from its own 16-bit down-counter, and each counter divides the base rate by a divisor written through a load port.

A third 16-bit counter acts as a shared prescaler. A select bit for each pacer counter chooses whether that counter is stepped by the base enable or by the prescaler's tick. When the prescaler is selected, the pacer rate is the base rate divided by the product of the two divisors. This extends the range well past 16 bits.

Every counter can raise a sticky interrupt-pending flag on its tick, gated by an enable bit for that counter. Software clears a flag by writing 1 to it. A single request line reports that at least one flag is pending.

Top module: `dual_pacer_gen`

## Requirements
- R1: After reset, all three tick outputs are low, all pending flags read 0 and the request line is low.
- R2: A counter that is not cascaded ticks once every N base enables, where N is its divisor. The first tick comes on the N-th base enable after its divisor was written.
- R3: When `casc_in` is 1, the input-pacer counter (index 0) steps only on prescaler ticks. `in_tick` then has a period of D0*D2 base enables.
- R4: When `casc_out` is 1, the output-pacer counter (index 1) steps only on prescaler ticks, giving a period of D1*D2. This choice does not depend on `casc_in`.
- R5: A divisor value of 0 acts as 65536.
- R6: Writing a divisor restarts that counter from the new value. A tick that would fall in the write cycle is suppressed, and the first tick after the write comes N steps later.
- R7: No counter advances or ticks in a cycle where its step source is low. With `base_en` low, all counters hold their state.
- R8: The pending flag of a counter (bit 0 = input pacer, bit 1 = output pacer, bit 2 = prescaler) is set on that counter's tick only when the matching `irq_en` bit is 1. A tick with the bit at 0 leaves the flag unchanged.
- R9: Pending flags stay set until a 1 is written to the matching `irq_clr` bit. If a set and a clear arrive in the same cycle, the flag stays set.
- R10: `irq` is 1 exactly when at least one pending flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_en | input | 1 | Base-rate clock enable, one pulse per base period |
| div_wr | input | 3 | Divisor write strobes, one per counter (bit 2 = prescaler) |
| div_data | input | 48 | Three packed 16-bit divisors, counter i in bits [16i+15:16i] |
| casc_in | input | 1 | Step the input pacer from the prescaler tick |
| casc_out | input | 1 | Step the output pacer from the prescaler tick |
| irq_en | input | 3 | Interrupt enable per counter |
| irq_clr | input | 3 | Write-1-to-clear strobes for the pending flags |
| in_tick | output | 1 | Input pacer tick |
| out_tick | output | 1 | Output pacer tick |
| pre_tick | output | 1 | Prescaler tick |
| irq_pend | output | 3 | Sticky pending flags |
| irq | output | 1 | OR of the pending flags |

## Verification
The divide function is tried with four kinds of divisor and select pattern. Coprime divisors with both selects off show that each stream counts only its own divisor. Input-only and output-only cascading show that the two select bits are independent and that the rate is a product rather than a sum. Both cascaded at once show that the shared prescaler feeds both pacers together. A divisor of 1 shows that a counter can tick on every base enable. A divisor of 0 separates a 65536 period from a stuck counter. A rewrite in the middle of a count separates a restart from a divisor that only takes effect at the next reload.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  localparam int unsigned NUM_CNT = 3;
  localparam int unsigned IDX_IN  = 0;
  localparam int unsigned IDX_OUT = 1;
  localparam int unsigned IDX_PRE = 2;

  typedef enum logic [1:0] {
    SRC_BASE  = 2'd0,
    SRC_PRESC = 2'd1
  } step_src_e;
endpackage

// File: rtl/pacer_down_counter.sv
module pacer_down_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             tick
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  // cnt holds remaining steps minus one; a zero divisor wraps to all ones,
  // which yields a full 2^CNT_W period
  assign at_zero = (cnt_q == '0);
  assign tick    = step & at_zero & ~load;

  always_comb begin
    div_d = div_q;
    cnt_d = cnt_q;
    if (load) begin
      div_d = load_val;
      cnt_d = load_val - ONE;
    end else if (step) begin
      if (at_zero) cnt_d = div_q - ONE;
      else         cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '1;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pacer_step_sel.sv
module pacer_step_sel (
  input  logic base_en,
  input  logic presc_tick,
  input  logic use_presc,
  output logic step
);
  import pacer_pkg::*;

  step_src_e src;

  assign src = use_presc ? SRC_PRESC : SRC_BASE;

  always_comb begin
    unique case (src)
      SRC_PRESC: step = presc_tick;
      default:   step = base_en;
    endcase
  end
endmodule

// File: rtl/pacer_irq_bank.sv
module pacer_irq_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend,
  output logic         any
);
  logic [N-1:0] pend_q, pend_d;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_flag
      always_comb begin
        pend_d[g] = pend_q[g];
        if (clr[g])          pend_d[g] = 1'b0;
        if (ev[g] && en[g])  pend_d[g] = 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
  assign any  = |pend_q;
endmodule

// File: rtl/dual_pacer_gen.sv
module dual_pacer_gen #(
  parameter int unsigned CNT_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             base_en,
  input  logic [pacer_pkg::NUM_CNT-1:0]    div_wr,
  input  logic [pacer_pkg::NUM_CNT*CNT_W-1:0] div_data,
  input  logic                             casc_in,
  input  logic                             casc_out,
  input  logic [pacer_pkg::NUM_CNT-1:0]    irq_en,
  input  logic [pacer_pkg::NUM_CNT-1:0]    irq_clr,
  output logic                             in_tick,
  output logic                             out_tick,
  output logic                             pre_tick,
  output logic [pacer_pkg::NUM_CNT-1:0]    irq_pend,
  output logic                             irq
);
  import pacer_pkg::*;

  localparam int unsigned NPACE = 2;

  logic             presc_tick;
  logic [NPACE-1:0] pace_tick;
  logic [NPACE-1:0] pace_step;
  logic [NPACE-1:0] pace_casc;

  assign pace_casc[IDX_IN]  = casc_in;
  assign pace_casc[IDX_OUT] = casc_out;

  pacer_down_counter #(.CNT_W(CNT_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (div_wr[IDX_PRE]),
    .load_val (div_data[IDX_PRE*CNT_W +: CNT_W]),
    .step     (base_en),
    .tick     (presc_tick)
  );

  genvar g;
  generate
    for (g = 0; g < NPACE; g++) begin : g_pace
      pacer_step_sel u_sel (
        .base_en    (base_en),
        .presc_tick (presc_tick),
        .use_presc  (pace_casc[g]),
        .step       (pace_step[g])
      );
      pacer_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (div_wr[g]),
        .load_val (div_data[g*CNT_W +: CNT_W]),
        .step     (pace_step[g]),
        .tick     (pace_tick[g])
      );
    end
  endgenerate

  assign in_tick  = pace_tick[IDX_IN];
  assign out_tick = pace_tick[IDX_OUT];
  assign pre_tick = presc_tick;

  pacer_irq_bank #(.N(NUM_CNT)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    ({presc_tick, pace_tick[IDX_OUT], pace_tick[IDX_IN]}),
    .en    (irq_en),
    .clr   (irq_clr),
    .pend  (irq_pend),
    .any   (irq)
  );
endmodule

// File: rtl/dual_pacer_gen_chk.sv
module dual_pacer_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       base_en,
  input logic       casc_in,
  input logic       casc_out,
  input logic [2:0] irq_en,
  input logic [2:0] irq_clr,
  input logic       in_tick,
  input logic       out_tick,
  input logic       pre_tick,
  input logic [2:0] irq_pend
);
  logic [2:0] ticks;
  assign ticks = {pre_tick, out_tick, in_tick};

  assert_pre_needs_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |-> base_en);
  assert_in_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tick && !casc_in) |-> base_en);
  assert_out_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tick && !casc_out) |-> base_en);
  assert_in_casc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tick && casc_in) |-> pre_tick);
  assert_out_casc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tick && casc_out) |-> pre_tick);

  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : g_flag
      assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ticks[g] && irq_en[g]) |=> irq_pend[g]);
      assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_pend[g] && !(ticks[g] && irq_en[g])) |=> !irq_pend[g]);
      assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend[g] && !irq_clr[g]) |=> irq_pend[g]);
      assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr[g] && !(ticks[g] && irq_en[g])) |=> !irq_pend[g]);
    end
  endgenerate
endmodule

bind dual_pacer_gen dual_pacer_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .base_en  (base_en),
  .casc_in  (casc_in),
  .casc_out (casc_out),
  .irq_en   (irq_en),
  .irq_clr  (irq_clr),
  .in_tick  (in_tick),
  .out_tick (out_tick),
  .pre_tick (pre_tick),
  .irq_pend (irq_pend)
);

// File: tb/dual_pacer_gen_tb.sv
`timescale 1ns/1ps
module dual_pacer_gen_tb;
  localparam int W = 16;

  logic          clk;
  logic          rst_n;
  logic          base_en;
  logic [2:0]    div_wr;
  logic [3*W-1:0] div_data;
  logic          casc_in, casc_out;
  logic [2:0]    irq_en, irq_clr;
  logic          in_tick, out_tick, pre_tick, irq;
  logic [2:0]    irq_pend;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  dual_pacer_gen #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .base_en(base_en), .div_wr(div_wr),
    .div_data(div_data), .casc_in(casc_in), .casc_out(casc_out),
    .irq_en(irq_en), .irq_clr(irq_clr), .in_tick(in_tick),
    .out_tick(out_tick), .pre_tick(pre_tick), .irq_pend(irq_pend), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // d0, d1, d2, casc_in, casc_out, cycles, expected in ticks, expected out ticks
  localparam int NV = 5;
  localparam int VEC [NV][8] = '{
    '{5, 7, 3, 0, 0, 105, 21, 15},   // R2 coprime, no cascade
    '{4, 3, 5, 1, 0, 120,  6, 40},   // R3 input cascaded only
    '{2, 6, 4, 0, 1,  96, 48,  4},   // R4 output cascaded only
    '{3, 2, 2, 1, 1,  60, 10, 15},   // R3 R4 both cascaded
    '{1, 1, 9, 0, 0,  20, 20, 20}    // R2 divisor 1
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int d0, input int d1, input int d2, input bit ci, input bit co);
    @(negedge clk);
    div_wr   = 3'b111;
    div_data = {d2[W-1:0], d1[W-1:0], d0[W-1:0]};
    casc_in  = ci;
    casc_out = co;
    @(posedge clk);
    #1 div_wr = 3'b000;
  endtask

  task automatic run(input int n, output int ci, output int co, output int first_in);
    ci = 0; co = 0; first_in = 0;
    for (int j = 1; j <= n; j++) begin
      @(negedge clk);
      #1;
      if (in_tick) begin
        ci++;
        if (first_in == 0) first_in = j;
      end
      if (out_tick) co++;
    end
  endtask

  initial begin
    int ci, co, fi;
    rst_n = 1'b0; base_en = 1'b0; div_wr = '0; div_data = '0;
    casc_in = 1'b0; casc_out = 1'b0; irq_en = '0; irq_clr = '0;
    repeat (3) @(posedge clk);
    #1;
    check(in_tick == 0 && out_tick == 0 && pre_tick == 0, "R1 ticks", {in_tick, out_tick, pre_tick}, 0);
    check(irq_pend == 3'b000, "R1 pend", irq_pend, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    @(negedge clk);
    rst_n = 1'b1;
    base_en = 1'b1;

    // vector table
    for (int v = 0; v < NV; v++) begin
      load(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3][0], VEC[v][4][0]);
      run(VEC[v][5], ci, co, fi);
      check(ci == VEC[v][6], $sformatf("R2/R3 vec%0d in", v), ci, VEC[v][6]);
      check(co == VEC[v][7], $sformatf("R2/R4 vec%0d out", v), co, VEC[v][7]);
    end

    // R5: zero divisor means 65536
    load(0, 5, 5, 0, 0);
    run(65536, ci, co, fi);
    check(ci == 1, "R5 count", ci, 1);
    check(fi == 65536, "R5 first tick", fi, 65536);

    // R6: rewrite mid-count restarts
    load(10, 5, 5, 0, 0);
    run(6, ci, co, fi);
    @(negedge clk);
    div_wr = 3'b001; div_data[W-1:0] = 16'd4;
    #1;
    check(in_tick == 0, "R6 write-cycle tick", in_tick, 0);
    @(posedge clk);
    #1 div_wr = 3'b000;
    run(8, ci, co, fi);
    check(fi == 4, "R6 first after restart", fi, 4);
    check(ci == 2, "R6 count", ci, 2);

    // R7: base_en low freezes
    load(7, 3, 5, 0, 0);
    @(negedge clk);
    base_en = 1'b0;
    run(10, ci, co, fi);
    check(ci == 0 && co == 0, "R7 frozen", ci + co, 0);
    @(negedge clk);
    base_en = 1'b1;
    #1;
    check(out_tick == 0, "R7 resume", out_tick, 0);
    run(2, ci, co, fi);
    check(co == 1, "R7 resume period", co, 1);

    // R8 R10: only enabled counter sets its flag
    irq_en = 3'b010;
    load(2, 3, 4, 0, 0);
    run(12, ci, co, fi);
    check(irq_pend == 3'b010, "R8 enable mask", irq_pend, 3'b010);
    check(irq == 1'b1, "R10 irq set", irq, 1);

    // R9: set wins over same-cycle clear, then clear works
    fi = 0;
    for (int k = 0; k < 6 && fi == 0; k++) begin
      @(negedge clk);
      #1;
      if (out_tick) begin
        fi = 1;
        #1 irq_clr = 3'b111;
      end
    end
    @(negedge clk);
    irq_clr = 3'b000;
    #1;
    check(irq_pend[1] == 1'b1, "R9 set wins", irq_pend[1], 1);
    check(out_tick == 0, "R9 no tick in clear cycle", out_tick, 0);
    irq_clr = 3'b111;
    @(negedge clk);
    irq_clr = 3'b000;
    #1;
    check(irq_pend == 3'b000, "R9 cleared", irq_pend, 0);
    check(irq == 1'b0, "R10 irq clear", irq, 0);
    irq_en = 3'b000;
    run(10, ci, co, fi);
    check(irq_pend == 3'b000, "R8 disabled stays clear", irq_pend, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule